// File: doc/BRIEF.md
# Video Timing Reference and Ancillary Flag Inserter

This block sits in a 10-bit component video path and, on command, overwrites the outgoing word stream with synchronisation markers. A timing reference marker is four words long. It starts with the preamble 3FF, 000, 000 and ends with a status word. The status word carries the field (F), vertical-blanking (V) and horizontal (H) flags, together with protection bits. A format input selects one of two status layouts. The first is the 4:2:2 layout. The second is the 4:4:4:4 layout, which also carries an S flag. On a separate command the block writes the three-word ancillary data flag 000, 3FF, 3FF. When no marker is being written, video passes through unchanged.

Every register advances only on cycles where the clock enable is high. A command is sampled on one enabled cycle, together with the flags for the marker. The marker words then take the places of the input words sampled on that cycle and on the following enabled cycles. Pass-through and inserted words both have a latency of one enabled cycle, so each inserted word lines up exactly with the input word it replaces. A command that arrives while a marker is still being written is dropped, and the block reports the drop with an error pulse.

Top module: `trs_inserter`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge drives `vid_o` to 000 and `req_err_o` to 0 and clears any marker in progress. After release, input words pass through at once.
- R2: When the block is idle and no command is present, an enabled edge loads `vid_o` with the `vid_i` word sampled at that same edge.
- R3: On an edge with `en` low, `vid_o`, `req_err_o` and the insertion progress all hold their values, and any command presented on that edge is ignored.
- R4: A command accepted on an enabled edge with `req_kind_i[1]`=0 makes that edge and the next three enabled edges output 3FF, 000, 000 and then the status word.
- R5: `req_kind_i[1]`=1 selects the ancillary flag. Otherwise `req_kind_i[0]` is the H flag: 1 gives an end-of-active-video marker and 0 gives a start-of-active-video marker.
- R6: With `fmt_i`=0 (4:2:2), the status word is: bit9=1, bit8=F, bit7=V, bit6=H, bit5=V^H, bit4=F^H, bit3=F^V, bit2=F^V^H, and bits 1..0=0.
- R7: With `fmt_i`=1 (4:4:4:4), the status word is: bit9=1, bit8=F, bit7=V, bit6=H, bit5=S, bit4=F^V^H, bit3=F^V^S, bit2=V^H^S, bit1=F^H^S, and bit0=0.
- R8: An accepted ancillary command makes that edge and the next two enabled edges output 000, 3FF, 3FF.
- R9: A command sampled on an enabled edge while a marker is still in progress does not change the output sequence. That edge sets `req_err_o` to 1. Every other enabled edge sets it to 0.
- R10: `fmt_i`, `f_i`, `v_i` and `s_i` are captured on the edge that accepts the command. Changes to them while the marker is being written do not affect its status word.
- R11: The enabled edge after the last marker word passes video through again or accepts a new command, so markers can follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; the pipeline advances only when high |
| vid_i | input | 10 | Incoming video word |
| req_i | input | 1 | Command to start a marker, sampled on enabled edges |
| req_kind_i | input | 2 | Marker kind: bit1 selects the ancillary flag, bit0 is H |
| fmt_i | input | 1 | Status layout: 0 = 4:2:2, 1 = 4:4:4:4 |
| f_i | input | 1 | Field flag for the status word |
| v_i | input | 1 | Vertical-blanking flag for the status word |
| s_i | input | 1 | Extra S flag, used only in the 4:4:4:4 layout |
| vid_o | output | 10 | Outgoing video word with markers inserted |
| req_err_o | output | 1 | Pulse: a command was dropped because a marker was in progress |

## Verification
All results are due exactly one enabled edge after the stimulus that causes them. The first marker word and any error pulse appear on the edge that samples the command. Each later marker word, and the status word as the fourth, appears one enabled edge after the word before it, and edges with `en` low do not count toward these delays. The bench applies each stimulus row just after a falling edge, lets one rising edge pass, and compares `vid_o` and `req_err_o` on the next falling edge. Rows with `en` low therefore expect the previous value to persist.

// File: rtl/trs_ins_pkg.sv
package trs_ins_pkg;

    localparam int VID_W   = 10;
    localparam int TRS_LEN = 4;
    localparam int ANC_LEN = 3;
    localparam int CNT_W   = $clog2(TRS_LEN);

    typedef logic [VID_W-1:0] word_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam word_t WORD_ONES  = {VID_W{1'b1}};
    localparam word_t WORD_ZEROS = {VID_W{1'b0}};

    typedef enum logic {
        SYM_TRS = 1'b0,
        SYM_ANC = 1'b1
    } sym_e;

    typedef enum logic {
        FMT_422  = 1'b0,
        FMT_4444 = 1'b1
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic f;
        logic v;
        logic h;
        logic s;
    } flags_t;

    function automatic word_t status_422(flags_t x);
        word_t w;
        w    = WORD_ZEROS;
        w[9] = 1'b1;
        w[8] = x.f;
        w[7] = x.v;
        w[6] = x.h;
        w[5] = x.v ^ x.h;
        w[4] = x.f ^ x.h;
        w[3] = x.f ^ x.v;
        w[2] = x.f ^ x.v ^ x.h;
        return w;
    endfunction

    function automatic word_t status_4444(flags_t x);
        word_t w;
        w    = WORD_ZEROS;
        w[9] = 1'b1;
        w[8] = x.f;
        w[7] = x.v;
        w[6] = x.h;
        w[5] = x.s;
        w[4] = x.f ^ x.v ^ x.h;
        w[3] = x.f ^ x.v ^ x.s;
        w[2] = x.v ^ x.h ^ x.s;
        w[1] = x.f ^ x.h ^ x.s;
        return w;
    endfunction

    // Fixed preamble word for a marker kind at a given position.
    function automatic word_t preamble_word(sym_e sym, cnt_t idx);
        if (sym == SYM_ANC) begin
            return (idx == '0) ? WORD_ZEROS : WORD_ONES;
        end
        return (idx == '0) ? WORD_ONES : WORD_ZEROS;
    endfunction

endpackage

// File: rtl/trs_ins_status_enc.sv
module trs_ins_status_enc
    import trs_ins_pkg::*;
(
    input  flags_t flags,
    output word_t  status
);
    word_t w_422;
    word_t w_4444;

    always_comb begin
        w_422  = status_422(flags);
        w_4444 = status_4444(flags);
        status = (flags.fmt == FMT_4444) ? w_4444 : w_422;
    end
endmodule

// File: rtl/trs_ins_seq.sv
module trs_ins_seq
    import trs_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       req_i,
    input  logic [1:0] req_kind_i,
    input  logic       fmt_i,
    input  logic       f_i,
    input  logic       v_i,
    input  logic       s_i,
    output logic       accept,
    output logic       busy,
    output sym_e       sym_cur,
    output cnt_t       idx,
    output flags_t     flags_q,
    output logic       req_err_o
);
    cnt_t remain;
    sym_e sym_new;

    assign sym_new = req_kind_i[1] ? SYM_ANC : SYM_TRS;
    assign busy    = (remain != '0);
    assign accept  = en && req_i && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain    <= '0;
            idx       <= '0;
            sym_cur   <= SYM_TRS;
            flags_q   <= '0;
            req_err_o <= 1'b0;
        end else if (en) begin
            req_err_o <= req_i && busy;
            if (busy) begin
                remain <= remain - cnt_t'(1);
                idx    <= idx + cnt_t'(1);
            end else if (req_i) begin
                sym_cur     <= sym_new;
                idx         <= cnt_t'(1);
                remain      <= (sym_new == SYM_ANC) ? cnt_t'(ANC_LEN - 1)
                                                    : cnt_t'(TRS_LEN - 1);
                flags_q.fmt <= fmt_e'(fmt_i);
                flags_q.f   <= f_i;
                flags_q.v   <= v_i;
                flags_q.h   <= req_kind_i[0];
                flags_q.s   <= s_i;
            end
        end
    end
endmodule

// File: rtl/trs_ins_outmux.sv
module trs_ins_outmux
    import trs_ins_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  accept,
    input  logic  busy,
    input  logic  kind_anc,
    input  sym_e  sym_cur,
    input  cnt_t  idx,
    input  word_t status,
    input  word_t vid_i,
    output word_t vid_o
);
    word_t nxt;

    always_comb begin
        if (accept) begin
            nxt = preamble_word(kind_anc ? SYM_ANC : SYM_TRS, '0);
        end else if (busy) begin
            if (sym_cur == SYM_TRS && idx == cnt_t'(TRS_LEN - 1)) begin
                nxt = status;
            end else begin
                nxt = preamble_word(sym_cur, idx);
            end
        end else begin
            nxt = vid_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_o <= WORD_ZEROS;
        end else if (en) begin
            vid_o <= nxt;
        end
    end
endmodule

// File: rtl/trs_inserter.sv
module trs_inserter
    import trs_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [9:0] vid_i,
    input  logic       req_i,
    input  logic [1:0] req_kind_i,
    input  logic       fmt_i,
    input  logic       f_i,
    input  logic       v_i,
    input  logic       s_i,
    output logic [9:0] vid_o,
    output logic       req_err_o
);
    logic   accept;
    logic   busy;
    sym_e   sym_cur;
    cnt_t   idx;
    flags_t flags_q;
    word_t  status;

    trs_ins_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .req_i      (req_i),
        .req_kind_i (req_kind_i),
        .fmt_i      (fmt_i),
        .f_i        (f_i),
        .v_i        (v_i),
        .s_i        (s_i),
        .accept     (accept),
        .busy       (busy),
        .sym_cur    (sym_cur),
        .idx        (idx),
        .flags_q    (flags_q),
        .req_err_o  (req_err_o)
    );

    trs_ins_status_enc u_enc (
        .flags  (flags_q),
        .status (status)
    );

    trs_ins_outmux u_mux (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .accept   (accept),
        .busy     (busy),
        .kind_anc (req_kind_i[1]),
        .sym_cur  (sym_cur),
        .idx      (idx),
        .status   (status),
        .vid_i    (vid_i),
        .vid_o    (vid_o)
    );
endmodule

// File: rtl/trs_inserter_chk.sv
module trs_inserter_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       req_i,
    input logic [1:0] req_kind_i,
    input logic [9:0] vid_i,
    input logic [9:0] vid_o,
    input logic       req_err_o,
    input logic       busy
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vid_o == 10'h000 && !req_err_o));

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && !$past(busy) && !$past(req_i))
        |-> vid_o == $past(vid_i));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> ($stable(vid_o) && $stable(req_err_o)));

    p_preamble_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && $past(req_i) && !$past(busy) && !$past(req_kind_i[1]))
        |-> vid_o == 10'h3FF);

    p_anc_first_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && $past(req_i) && !$past(busy) && $past(req_kind_i[1]))
        |-> vid_o == 10'h000);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst)) |-> (req_err_o == ($past(req_i) && $past(busy))));
endmodule

bind trs_inserter trs_inserter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .req_i      (req_i),
    .req_kind_i (req_kind_i),
    .vid_i      (vid_i),
    .vid_o      (vid_o),
    .req_err_o  (req_err_o),
    .busy       (busy)
);

// File: tb/trs_inserter_bench.sv
module trs_inserter_bench;

    typedef struct packed {
        logic       en;
        logic       req;
        logic [1:0] kind;
        logic       fmt;
        logic       f;
        logic       v;
        logic       s;
        logic [9:0] vid;
        logic [9:0] exp_vid;
        logic       exp_err;
    } row_t;

    localparam int NV = 34;

    // en req kind fmt f v s vid exp_vid exp_err
    localparam row_t ROWS [NV] = '{
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h123,10'h123,1'b0}, // R2
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h0AA,10'h0AA,1'b0}, // R2
        '{1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,10'h111,10'h3FF,1'b0}, // R4 SAV
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h112,10'h000,1'b0}, // R4
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,10'h113,10'h000,1'b0}, // R4, flags change R10
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,10'h114,10'h200,1'b0}, // R6 R10
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h115,10'h115,1'b0}, // R11
        '{1'b1,1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,10'h116,10'h3FF,1'b0}, // R5 EAV
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h117,10'h000,1'b0}, // R4
        '{1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,10'h118,10'h000,1'b1}, // R9
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h119,10'h274,1'b0}, // R5 R6
        '{1'b1,1'b1,2'b01,1'b0,1'b1,1'b1,1'b0,10'h11A,10'h3FF,1'b0}, // R11
        '{1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h3AB,10'h3FF,1'b0}, // R3
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h11B,10'h000,1'b0}, // R4
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h11C,10'h000,1'b0}, // R4
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h11D,10'h3C4,1'b0}, // R6
        '{1'b1,1'b1,2'b01,1'b1,1'b0,1'b0,1'b1,10'h11E,10'h3FF,1'b0}, // R7
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h11F,10'h000,1'b0}, // R7
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h120,10'h000,1'b0}, // R7
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h121,10'h278,1'b0}, // R7
        '{1'b1,1'b1,2'b00,1'b1,1'b1,1'b0,1'b0,10'h122,10'h3FF,1'b0}, // R7
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h124,10'h000,1'b0}, // R7
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h125,10'h000,1'b0}, // R7
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h126,10'h31A,1'b0}, // R7
        '{1'b1,1'b1,2'b10,1'b0,1'b0,1'b0,1'b0,10'h127,10'h000,1'b0}, // R8
        '{1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,10'h128,10'h3FF,1'b1}, // R8 R9
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h129,10'h3FF,1'b0}, // R8
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h155,10'h155,1'b0}, // R11
        '{1'b1,1'b1,2'b00,1'b0,1'b1,1'b0,1'b0,10'h12A,10'h3FF,1'b0}, // R4
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h12B,10'h000,1'b0}, // R4
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h12C,10'h000,1'b0}, // R4
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h12D,10'h31C,1'b0}, // R6
        '{1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,10'h200,10'h31C,1'b0}, // R3
        '{1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,10'h2BC,10'h2BC,1'b0}  // R3 R2
    };

    string tags [NV] = '{
        "R2","R2","R4","R4","R4 R10","R6 R10","R11","R5","R4","R9","R5 R6",
        "R11","R3","R4","R4","R6","R7","R7","R7","R7","R7","R7","R7","R7",
        "R8","R8 R9","R8","R11","R4","R4","R4","R6","R3","R3 R2"
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [9:0] vid_i = '0;
    logic       req_i = 1'b0;
    logic [1:0] req_kind_i = '0;
    logic       fmt_i = 1'b0;
    logic       f_i = 1'b0;
    logic       v_i = 1'b0;
    logic       s_i = 1'b0;
    logic [9:0] vid_o;
    logic       req_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trs_inserter u_trs_inserter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .vid_i      (vid_i),
        .req_i      (req_i),
        .req_kind_i (req_kind_i),
        .fmt_i      (fmt_i),
        .f_i        (f_i),
        .v_i        (v_i),
        .s_i        (s_i),
        .vid_o      (vid_o),
        .req_err_o  (req_err_o)
    );

    task automatic chk_vid(string tag, logic [9:0] exp);
        checks++;
        if (vid_o !== exp) begin
            errors++;
            $display("FAIL %s vid_o actual=%h expected=%h", tag, vid_o, exp);
        end
    endtask

    task automatic chk_err(string tag, logic exp);
        checks++;
        if (req_err_o !== exp) begin
            errors++;
            $display("FAIL %s req_err_o actual=%b expected=%b", tag, req_err_o, exp);
        end
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_vid("R1", 10'h000);
        chk_err("R1", 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            en         = ROWS[i].en;
            req_i      = ROWS[i].req;
            req_kind_i = ROWS[i].kind;
            fmt_i      = ROWS[i].fmt;
            f_i        = ROWS[i].f;
            v_i        = ROWS[i].v;
            s_i        = ROWS[i].s;
            vid_i      = ROWS[i].vid;
            @(negedge clk);
            chk_vid(tags[i], ROWS[i].exp_vid);
            chk_err(tags[i], ROWS[i].exp_err);
        end

        // R1: reset in the middle of a marker clears it
        en = 1'b1; req_i = 1'b1; req_kind_i = 2'b00; vid_i = 10'h0F1;
        @(negedge clk);
        chk_vid("R4", 10'h3FF);
        req_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk_vid("R1", 10'h000);
        chk_err("R1", 1'b0);
        rst = 1'b0; vid_i = 10'h0F0;
        @(negedge clk);
        chk_vid("R1", 10'h0F0);
        vid_i = 10'h0F2;
        @(negedge clk);
        chk_vid("R1", 10'h0F2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule